// File: doc/BRIEF.md
# Timing Mode Controller

This block chooses the operating mode of a network clock module and reports which mode is in effect. A two-bit control word picks one of four modes: free run, reference 1, reference 2 or holdover. The block first debounces that word. After a reference is chosen, the block runs a timed fast-acquisition phase. It then settles into normal locked operation. It drops back into fast acquisition if the phase detector reports an excessive phase error.

A mode alarm is raised whenever the module is not locked normally. This covers free run, holdover, fast acquisition, and a lost reference. On a lost reference the chosen mode is kept and the loop holds its last frequency, a pseudo-holdover.

An output-enable request lets the pad drivers be disabled while the state keeps running. An active-low reset returns everything to free run.

Control, reset and tri-state pins are asynchronous and pass through two-flop synchronizers. Loss-of-reference and phase-error flags come from neighbouring logic on the same clock. All intervals are counted in millisecond ticks. These ticks are derived from a timebase pulse input with a parameterized division ratio.

Top module: `tmode_ctrl`

## Requirements
- R1: The control word {ctrl_b, ctrl_a} selects the mode: 00 free run, 01 reference 1, 10 reference 2, 11 holdover. The status word {status1, status0} reports the mode in effect with the same encoding.
- R2: During and after reset with both control inputs low, status is 00, fast_acq is 0 and mode_alarm is 1.
- R3: A control change reaches the status outputs in the following way:
  - the change passes two synchronizer stages;
  - it must then hold through QUAL_MS+1 millisecond ticks;
  - it then passes one mode register.
  With a millisecond tick on every clock, status changes exactly QUAL_MS+5 clock edges after the control inputs change.
- R4: A control change that reverts before it has been qualified has no effect on the status outputs.
- R5: Entering reference 1 or reference 2 raises fast_acq in the same edge that status changes. fast_acq clears after exactly ACQ_MS millisecond ticks, at which point normal locked operation begins.
- R6: mode_alarm is 1 in each of these cases:
  - in free run;
  - in holdover;
  - during fast acquisition;
  - whenever lor is 1.
  It is 0 only in a locked reference mode without lor. fast_acq is never 1 outside a reference mode.
- R7: phase_err on an edge in locked operation restarts a full fast acquisition from that edge. phase_err is ignored during fast acquisition, in free run and in holdover.
- R8: lor raises mode_alarm in the same cycle and leaves the status outputs unchanged. While lor is 1, the fast-acquisition timer does not advance.
- R9: tristate high drives out_en low two edges later. Mode changes continue to reach the status outputs while out_en is low. Releasing tristate restores out_en two edges later with the current status.
- R10: rst_n low clears the status to free run and fast_acq to 0 at once, without waiting for a clock. After release with a reference still selected, a complete new fast acquisition starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_tick | input | 1 | Timebase pulse, TICKS_PER_MS per millisecond |
| ctrl_a | input | 1 | Mode control bit 0 (asynchronous) |
| ctrl_b | input | 1 | Mode control bit 1 (asynchronous) |
| tristate | input | 1 | Request to disable output drivers (asynchronous) |
| lor | input | 1 | Active reference lost |
| phase_err | input | 1 | Phase error above the re-acquisition limit |
| status0 | output | 1 | Mode in effect, bit 0 |
| status1 | output | 1 | Mode in effect, bit 1 |
| mode_alarm | output | 1 | Not in normal locked operation |
| fast_acq | output | 1 | Fast acquisition in progress |
| out_en | output | 1 | Enable for the output pad drivers |

## Verification
Different internal faults show up at different ports and at different times:
- A corrupted qualifier counter or candidate register shows on the status outputs as a mode change one or more edges early or late, or a glitch that gets through.
- A faulty acquisition counter shows up ACQ_MS ticks after entry, as a fast_acq fall at the wrong edge.
- A counter that keeps running under lor, or that restarts on phase_err during acquisition, shows as a shifted fall of fast_acq.

The bench therefore samples status and fast_acq on exactly the predicted edge and on the edge before it, across every mode and each ignored stimulus.

// File: rtl/tmode_pkg.sv
package tmode_pkg;

   typedef enum logic [1:0] {
      MODE_FREE = 2'b00,
      MODE_REF1 = 2'b01,
      MODE_REF2 = 2'b10,
      MODE_HOLD = 2'b11
   } mode_e;

   function automatic logic is_ref(mode_e m);
      return (m == MODE_REF1) || (m == MODE_REF2);
   endfunction

endpackage

// File: rtl/tmode_sync.sv
// Multi-stage synchronizer with asynchronous clear; also used as a reset
// synchronizer by tying d high.
module tmode_sync #(
   parameter int               WIDTH  = 1,
   parameter int               STAGES = 2,
   parameter logic [WIDTH-1:0] INIT   = '0
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tmode_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("tmode_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) stg <= {STAGES{INIT}};
      else         stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/tmode_tick.sv
// Divides the timebase pulse down to a registered millisecond tick.
module tmode_tick #(
   parameter int DIV = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   output logic ms_tick
);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("tmode_tick: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_direct
         logic ms_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ms_q <= 1'b0;
            else        ms_q <= tick_in;
         end
         assign ms_tick = ms_q;
      end else begin : g_divided
         localparam int            CW   = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt;
         logic          ms_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               ms_q <= 1'b0;
            end else begin
               ms_q <= tick_in && (cnt == LAST);
               if (tick_in) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
         end
         assign ms_tick = ms_q;

         // R3: with a ratio above one, two ticks never come back to back
         assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ms_tick |=> !ms_tick);
      end
   endgenerate

endmodule

// File: rtl/tmode_qual.sv
// Accepts a synchronized control word only after it has been stable for
// QUAL_MS+1 millisecond ticks.
module tmode_qual
   import tmode_pkg::*;
#(
   parameter int QUAL_MS = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ms_tick,
   input  mode_e ctrl_s,
   output mode_e qual
);

   generate
      if (QUAL_MS < 1) begin : g_bad_qual
         $error("tmode_qual: QUAL_MS must be at least 1");
      end
   endgenerate

   localparam int            QW    = $clog2(QUAL_MS + 1);
   localparam logic [QW-1:0] QLAST = QW'(QUAL_MS);

   mode_e         cand_q;
   mode_e         qual_q;
   logic [QW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_q <= MODE_FREE;
         qual_q <= MODE_FREE;
         cnt    <= '0;
      end else if (ctrl_s != cand_q) begin
         cand_q <= ctrl_s;
         cnt    <= '0;
      end else if (ms_tick) begin
         if (cnt == QLAST) qual_q <= cand_q;
         else              cnt    <= cnt + 1'b1;
      end
   end

   assign qual = qual_q;

   // R3: a new qualified value must come from a candidate that ran out its window
   assert_qual_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (qual_q != $past(qual_q)) |-> ($past(cnt) == QLAST && $past(cand_q) == qual_q));

   // R4: the qualified value never moves while the candidate is being replaced
   assert_qual_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_s != cand_q) |=> $stable(qual_q));

endmodule

// File: rtl/tmode_fsm.sv
// Mode register, fast-acquisition timer and alarm decode.
module tmode_fsm
   import tmode_pkg::*;
#(
   parameter int ACQ_MS = 100000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ms_tick,
   input  mode_e qual,
   input  logic  lor,
   input  logic  phase_err,
   output mode_e status,
   output logic  fast_acq,
   output logic  alarm
);

   generate
      if (ACQ_MS < 2) begin : g_bad_acq
         $error("tmode_fsm: ACQ_MS must be at least 2");
      end
   endgenerate

   localparam int            AW       = $clog2(ACQ_MS);
   localparam logic [AW-1:0] ACQ_LAST = AW'(ACQ_MS - 1);

   mode_e         mode_q;
   logic          acq_q;
   logic [AW-1:0] acq_cnt;
   logic          in_ref;

   assign in_ref = is_ref(mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_FREE;
         acq_q   <= 1'b0;
         acq_cnt <= '0;
      end else if (qual != mode_q) begin
         mode_q  <= qual;
         acq_q   <= is_ref(qual);
         acq_cnt <= '0;
      end else if (in_ref) begin
         if (!acq_q) begin
            if (phase_err && !lor) begin
               acq_q   <= 1'b1;
               acq_cnt <= '0;
            end
         end else if (ms_tick && !lor) begin
            if (acq_cnt == ACQ_LAST) acq_q   <= 1'b0;
            else                     acq_cnt <= acq_cnt + 1'b1;
         end
      end
   end

   assign status   = mode_q;
   assign fast_acq = acq_q;
   assign alarm    = !in_ref || acq_q || lor;

   // R5: a newly entered reference mode always begins in fast acquisition
   assert_entry_acq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != $past(mode_q) && in_ref) |-> acq_q);

   // R8: the acquisition timer is frozen while the reference is lost
   assert_lor_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lor && acq_q && qual == mode_q) |=> (acq_q && $stable(acq_cnt)));

   // R7: a phase error in locked operation restarts acquisition from zero
   assert_perr_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ref && !acq_q && phase_err && !lor && qual == mode_q) |=> (acq_q && acq_cnt == '0));

endmodule

// File: rtl/tmode_ctrl.sv
// Operating-mode controller for a network clock module.
module tmode_ctrl
   import tmode_pkg::*;
#(
   parameter int TICKS_PER_MS = 1000,
   parameter int QUAL_MS      = 2,
   parameter int ACQ_MS       = 100000,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tb_tick,
   input  logic ctrl_a,
   input  logic ctrl_b,
   input  logic tristate,
   input  logic lor,
   input  logic phase_err,
   output logic status0,
   output logic status1,
   output logic mode_alarm,
   output logic fast_acq,
   output logic out_en
);

   logic       rst_i;
   logic [2:0] pins_s;
   logic       ms_tick;
   mode_e      qual;
   mode_e      status;

   tmode_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .INIT(1'b0)) u_rst_sync (
      .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_i));

   tmode_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b000)) u_pin_sync (
      .clk(clk), .arst_n(rst_i), .d({tristate, ctrl_b, ctrl_a}), .q(pins_s));

   tmode_tick #(.DIV(TICKS_PER_MS)) u_tick (
      .clk(clk), .rst_n(rst_i), .tick_in(tb_tick), .ms_tick(ms_tick));

   tmode_qual #(.QUAL_MS(QUAL_MS)) u_qual (
      .clk(clk), .rst_n(rst_i), .ms_tick(ms_tick),
      .ctrl_s(mode_e'(pins_s[1:0])), .qual(qual));

   tmode_fsm #(.ACQ_MS(ACQ_MS)) u_fsm (
      .clk(clk), .rst_n(rst_i), .ms_tick(ms_tick), .qual(qual),
      .lor(lor), .phase_err(phase_err),
      .status(status), .fast_acq(fast_acq), .alarm(mode_alarm));

   assign status0 = status[0];
   assign status1 = status[1];
   assign out_en  = !pins_s[2];

   // R6: fast acquisition only ever appears inside a reference mode
   assert_acq_in_ref_R6: assert property (@(posedge clk) disable iff (!rst_i)
      fast_acq |-> (status0 ^ status1));

   // R6: free run and holdover always carry the alarm
   assert_alarm_nonref_R6: assert property (@(posedge clk) disable iff (!rst_i)
      (status0 == status1) |-> mode_alarm);

   // R6: acquisition always carries the alarm
   assert_alarm_acq_R6: assert property (@(posedge clk) disable iff (!rst_i)
      fast_acq |-> mode_alarm);

endmodule

// File: tb/tmode_ctrl_tb.sv
`timescale 1ns/1ps
module tmode_ctrl_tb;

   localparam int QUAL = 3;
   localparam int ACQ  = 20;
   localparam int LAT  = QUAL + 5;

   logic clk = 1'b0;
   logic rst_n, tb_tick, ctrl_a, ctrl_b, tristate, lor, phase_err;
   logic status0, status1, mode_alarm, fast_acq, out_en;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   tmode_ctrl #(.TICKS_PER_MS(1), .QUAL_MS(QUAL), .ACQ_MS(ACQ), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b),
      .tristate(tristate), .lor(lor), .phase_err(phase_err),
      .status0(status0), .status1(status1), .mode_alarm(mode_alarm),
      .fast_acq(fast_acq), .out_en(out_en));

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic sel(logic [1:0] m);
      {ctrl_b, ctrl_a} = m;
   endtask

   function automatic logic [1:0] st();
      return {status1, status0};
   endfunction

   initial begin
      rst_n = 1'b0; tb_tick = 1'b1; ctrl_a = 1'b0; ctrl_b = 1'b0;
      tristate = 1'b0; lor = 1'b0; phase_err = 1'b0;
      tick(3);
      chk("R2 status in reset", {2'b0, st()}, 4'h0);
      chk("R2 fast_acq in reset", {3'b0, fast_acq}, 4'h0);
      chk("R2 alarm in reset", {3'b0, mode_alarm}, 4'h1);
      rst_n = 1'b1;
      tick(20);
      chk("R2 free run after reset", {2'b0, st()}, 4'h0);
      chk("R2 alarm in free run", {3'b0, mode_alarm}, 4'h1);

      // R4: short glitch on the control word
      sel(2'b01); tick(QUAL); sel(2'b00); tick(LAT + 5);
      chk("R4 glitch ignored", {2'b0, st()}, 4'h0);

      // R3/R1/R5: select reference 1
      sel(2'b01); tick(LAT - 1);
      chk("R3 status before qualification", {2'b0, st()}, 4'h0);
      tick(1);
      chk("R1 R3 status ref1", {2'b0, st()}, 4'h1);
      chk("R5 fast_acq on entry", {3'b0, fast_acq}, 4'h1);
      chk("R6 alarm in acquisition", {3'b0, mode_alarm}, 4'h1);
      tick(ACQ - 1);
      chk("R5 fast_acq last tick", {3'b0, fast_acq}, 4'h1);
      tick(1);
      chk("R5 locked after ACQ", {3'b0, fast_acq}, 4'h0);
      chk("R6 alarm low when locked", {3'b0, mode_alarm}, 4'h0);

      // R7: phase error restarts; a second one during acquisition is ignored
      phase_err = 1'b1; tick(1); phase_err = 1'b0;
      chk("R7 restart on phase error", {3'b0, fast_acq}, 4'h1);
      tick(5); phase_err = 1'b1; tick(1); phase_err = 1'b0;
      tick(ACQ - 7);
      chk("R7 acquisition not extended", {3'b0, fast_acq}, 4'h1);
      tick(1);
      chk("R7 acquisition ends on time", {3'b0, fast_acq}, 4'h0);

      // R8: lost reference in locked operation
      lor = 1'b1; #1;
      chk("R8 alarm same cycle", {3'b0, mode_alarm}, 4'h1);
      tick(3);
      chk("R8 status kept", {2'b0, st()}, 4'h1);
      chk("R8 no acquisition", {3'b0, fast_acq}, 4'h0);
      lor = 1'b0; #1;
      chk("R8 alarm clears", {3'b0, mode_alarm}, 4'h0);

      // R8: timer frozen during lor
      tick(1);
      phase_err = 1'b1; tick(1); phase_err = 1'b0;
      tick(2); lor = 1'b1; tick(5); lor = 1'b0;
      tick(ACQ - 3);
      chk("R8 timer frozen under lor", {3'b0, fast_acq}, 4'h1);
      tick(1);
      chk("R8 acquisition ends late by lor time", {3'b0, fast_acq}, 4'h0);

      // R1/R5: reference 2
      sel(2'b10); tick(LAT);
      chk("R1 status ref2", {2'b0, st()}, 4'h2);
      chk("R5 fast_acq on ref2 entry", {3'b0, fast_acq}, 4'h1);
      tick(ACQ);
      chk("R5 ref2 locked", {3'b0, fast_acq}, 4'h0);

      // R1/R6/R7/R8: holdover ignores lor and phase error
      sel(2'b11); tick(LAT);
      chk("R1 status holdover", {2'b0, st()}, 4'h3);
      chk("R6 alarm in holdover", {3'b0, mode_alarm}, 4'h1);
      phase_err = 1'b1; lor = 1'b1; tick(2); phase_err = 1'b0; lor = 1'b0;
      tick(1);
      chk("R7 phase error ignored in holdover", {3'b0, fast_acq}, 4'h0);
      chk("R8 lor ignored in holdover", {2'b0, st()}, 4'h3);

      // R9: tri-state
      tristate = 1'b1; tick(1);
      chk("R9 out_en after one edge", {3'b0, out_en}, 4'h1);
      tick(1);
      chk("R9 out_en low", {3'b0, out_en}, 4'h0);
      sel(2'b00); tick(LAT);
      chk("R9 state runs while disabled", {2'b0, st()}, 4'h0);
      tristate = 1'b0; tick(2);
      chk("R9 out_en restored", {3'b0, out_en}, 4'h1);
      chk("R9 status valid on release", {2'b0, st()}, 4'h0);

      // R10: asynchronous reset from locked reference operation
      sel(2'b01); tick(LAT + ACQ + 2);
      chk("R10 locked before reset", {2'b0, st(), fast_acq, mode_alarm}, 4'h4);
      rst_n = 1'b0; #1;
      chk("R10 async clear", {2'b0, st()}, 4'h0);
      chk("R10 fast_acq cleared", {3'b0, fast_acq}, 4'h0);
      tick(2); rst_n = 1'b1;
      tick(LAT + 4);
      chk("R10 reacquires after reset", {2'b0, st(), fast_acq, 1'b0}, 4'h6);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         vectors++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule